// File: doc/BRIEF.md
# Critical-Conduction Boost PFC Gate Sequencer

This block drives the gate of a boost power-factor-correction switch operating at the boundary between continuous and discontinuous inductor current. Each switching cycle it turns the switch on for a programmed number of clocks. It then holds the gate low until an auxiliary-winding zero-current signal first rises and then falls, which shows that the inductor has emptied. At that point the next on-time starts. When no valid zero-current pair arrives, a restart timer forces a turn-on at a fixed period. The same timer keeps running after a forced turn-on, so the stage can start again from standstill.

All comparator decisions arrive as digital levels and pass through a synchroniser inside the block. An over-current level cuts the present on-time short once a short blanking window has passed. A bus over-voltage level holds the gate low, and when it releases the block issues one forced pulse at once. A bus under-voltage level holds the gate low and raises a request to the supply-undervoltage logic. A fault flag from the lamp-driver side disables switching while it is present. Near the zero-crossings of the rectified line, the on-time is lengthened by a fixed fraction of itself, which reduces crossover distortion.

Top module: `pfc_gate_seq`

## Requirements
- R1: While reset is active and directly after it, gate_o is 0, uvlo_req_o is 0 and wd_active_o is 1, so the block waits for the restart timer.
- R2: When no valid zero-current pair arrives, forced turn-ons start exactly WD_CYCLES clocks apart. The period is measured from one gate rising edge to the next, because the timer restarts on every turn-on.
- R3: Every turn-on, whether normal or forced, keeps gate_o high for exactly ton_i clocks. The value of ton_i is captured at turn-on. A value of 0 gives a one-clock pulse.
- R4: When near_zc_i is 1 at turn-on, the pulse lasts ton_i + floor(ton_i / 2^EXT_SHIFT) clocks, which is ton_i + floor(ton_i/4) with the default shift of 2.
- R5: A falling zero-current edge turns the gate on only when a rising edge was seen after the previous turn-on, while the gate was low. The gate then goes high 3 clocks after the input falls. A falling edge with no such rising edge before it is ignored.
- R6: If the over-current level is high when an on-time has run BLANK_CYCLES clocks, the gate drops. With the level held high the pulse lasts BLANK_CYCLES+1 clocks. The next turn-on then waits for the timer or a valid zero-current pair.
- R7: While bus_ov_i is high the gate stays low. When it falls, a pulse of the programmed on-time starts 3 clocks later.
- R8: bus_uv_i raises uvlo_req_o 2 clocks later and holds the gate low. When bus_uv_i releases, uvlo_req_o clears 2 clocks later, and the first forced turn-on starts WD_CYCLES+3 clocks after the release.
- R9: fault_i holds the gate low without raising uvlo_req_o. When fault_i releases, the first forced turn-on starts WD_CYCLES+3 clocks later.
- R10: wd_active_o is 1 after a forced turn-on or a protection release, and it goes to 0 together with the gate rising edge of a normal zero-current turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zcd_i | input | 1 | Zero-current detect comparator level |
| ocp_i | input | 1 | Switch over-current comparator level |
| bus_ov_i | input | 1 | Bus over-voltage level, hysteresis applied outside |
| bus_uv_i | input | 1 | Bus under-voltage level |
| fault_i | input | 1 | Lamp-driver fault flag |
| ton_i | input | ONW | On-time in clocks from the error amplifier |
| near_zc_i | input | 1 | Rectified line is near a zero-crossing |
| gate_o | output | 1 | Boost switch gate command |
| uvlo_req_o | output | 1 | Request to enter supply undervoltage lockout |
| wd_active_o | output | 1 | Restart-timer mode indicator |

## Verification
A lost or wrongly set arm flag changes the clock count from a zero-current fall to the gate rising edge. A fall that is ignored only shows up one full timer period later, as a forced edge at the wrong moment, so the bench checks the exact period and the exact latency. A wrong on-time or blanking counter shows up within the same pulse as a wrong high width. A protection path that leaks shows up as any gate activity during a hold window of two timer periods, or as a release latency that is off by some number of clocks.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_ON   = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic zcd;
      logic ocp;
      logic ov;
      logic uv;
      logic flt;
   } cmp_vec_t;

   localparam int CMP_W = $bits(cmp_vec_t);

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pfc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pfc_sync: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pfc_ontime.sv
module pfc_ontime #(
   parameter int ONW          = 12,
   parameter int BLANK_CYCLES = 4,
   parameter int EXT_SHIFT    = 2,
   parameter bit EXT_EN       = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic           run_i,
   input  logic [ONW-1:0] ton_i,
   input  logic           near_zc_i,
   input  logic           ocp_i,
   output logic           done_o,
   output logic           ocp_trip_o
);

   localparam int LW = ONW + 1;
   localparam int BW = $clog2(BLANK_CYCLES + 1) + 1;

   if (EXT_EN && EXT_SHIFT < 2) begin : g_bad_shift
      $error("pfc_ontime: EXT_SHIFT below 2 exceeds a quarter extension");
   end
   if (ONW < 2) begin : g_bad_onw
      $error("pfc_ontime: ONW must be at least 2");
   end

   logic [ONW-1:0] ext;
   logic [LW-1:0]  len_raw;
   logic [LW-1:0]  len_eff;
   logic [LW-1:0]  cnt_q;
   logic [BW-1:0]  el_q;

   if (EXT_EN) begin : g_ext
      assign ext = near_zc_i ? (ton_i >> EXT_SHIFT) : '0;
   end else begin : g_noext
      logic unused_near;
      assign unused_near = near_zc_i;
      assign ext = '0;
   end

   assign len_raw = {1'b0, ton_i} + {1'b0, ext};
   assign len_eff = (len_raw == '0) ? LW'(1) : len_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         el_q  <= '0;
      end else if (load_i) begin
         cnt_q <= len_eff;
         el_q  <= '0;
      end else if (run_i) begin
         if (cnt_q != '0) cnt_q <= cnt_q - LW'(1);
         if (el_q != BW'(BLANK_CYCLES)) el_q <= el_q + BW'(1);
      end
   end

   assign done_o     = run_i && (cnt_q <= LW'(1));
   assign ocp_trip_o = run_i && ocp_i && (el_q == BW'(BLANK_CYCLES));

endmodule

// File: rtl/pfc_watchdog.sv
module pfc_watchdog #(
   parameter int WD_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic expire_o
);

   localparam int CW = $clog2(WD_CYCLES);

   if (WD_CYCLES < 2) begin : g_bad_period
      $error("pfc_watchdog: WD_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt_q <= '0;
      else if (clr_i)                          cnt_q <= '0;
      else if (cnt_q != CW'(WD_CYCLES - 1))    cnt_q <= cnt_q + CW'(1);
   end

   assign expire_o = (cnt_q == CW'(WD_CYCLES - 1));

endmodule

// File: rtl/pfc_gate_seq.sv
module pfc_gate_seq
   import pfc_gate_pkg::*;
#(
   parameter int ONW          = 12,
   parameter int WD_CYCLES    = 4000,
   parameter int SYNC_STAGES  = 2,
   parameter int BLANK_CYCLES = 4,
   parameter int EXT_SHIFT    = 2,
   parameter bit EXT_EN       = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           zcd_i,
   input  logic           ocp_i,
   input  logic           bus_ov_i,
   input  logic           bus_uv_i,
   input  logic           fault_i,
   input  logic [ONW-1:0] ton_i,
   input  logic           near_zc_i,
   output logic           gate_o,
   output logic           uvlo_req_o,
   output logic           wd_active_o
);

   if (BLANK_CYCLES < 0) begin : g_bad_blank
      $error("pfc_gate_seq: BLANK_CYCLES must not be negative");
   end

   logic [CMP_W-1:0] raw_v;
   logic [CMP_W-1:0] syn_v;
   cmp_vec_t         syn;

   assign raw_v = {zcd_i, ocp_i, bus_ov_i, bus_uv_i, fault_i};

   pfc_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_v),
      .q_o   (syn_v)
   );

   assign syn = cmp_vec_t'(syn_v);

   seq_state_t state_q, state_d;
   logic zcd_prev_q, armed_q, wd_mode_q, ov_seen_q;
   logic zcd_rise, zcd_fall, inhibit;
   logic trig_norm, trig_wd, exit_hold, start_on;
   logic wd_expire, on_done, ocp_trip;

   assign zcd_rise  = syn.zcd && !zcd_prev_q;
   assign zcd_fall  = !syn.zcd && zcd_prev_q;
   assign inhibit   = syn.ov || syn.uv || syn.flt;

   assign trig_norm = (state_q == ST_WAIT) && zcd_fall && armed_q;
   assign trig_wd   = (state_q == ST_WAIT) && wd_expire;
   assign exit_hold = (state_q == ST_HOLD) && !inhibit;
   assign start_on  = !inhibit && (trig_norm || trig_wd || (exit_hold && ov_seen_q));

   pfc_ontime #(
      .ONW          (ONW),
      .BLANK_CYCLES (BLANK_CYCLES),
      .EXT_SHIFT    (EXT_SHIFT),
      .EXT_EN       (EXT_EN)
   ) u_ontime (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_on),
      .run_i      (state_q == ST_ON),
      .ton_i      (ton_i),
      .near_zc_i  (near_zc_i),
      .ocp_i      (syn.ocp),
      .done_o     (on_done),
      .ocp_trip_o (ocp_trip)
   );

   pfc_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_on || (state_q == ST_HOLD)),
      .expire_o (wd_expire)
   );

   always_comb begin
      state_d = state_q;
      if (inhibit) begin
         state_d = ST_HOLD;
      end else begin
         unique case (state_q)
            ST_WAIT: if (start_on)             state_d = ST_ON;
            ST_ON:   if (on_done || ocp_trip)  state_d = ST_WAIT;
            ST_HOLD: state_d = ov_seen_q ? ST_ON : ST_WAIT;
            default: state_d = ST_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_WAIT;
         zcd_prev_q <= 1'b0;
         armed_q    <= 1'b0;
         wd_mode_q  <= 1'b1;
         ov_seen_q  <= 1'b0;
      end else begin
         state_q    <= state_d;
         zcd_prev_q <= syn.zcd;

         if (start_on || exit_hold)                 armed_q <= 1'b0;
         else if (state_q == ST_WAIT && zcd_rise)   armed_q <= 1'b1;

         if (start_on)       wd_mode_q <= !trig_norm;
         else if (exit_hold) wd_mode_q <= 1'b1;

         if (syn.ov)         ov_seen_q <= 1'b1;
         else if (exit_hold) ov_seen_q <= 1'b0;
      end
   end

   assign gate_o      = (state_q == ST_ON);
   assign uvlo_req_o  = syn.uv;
   assign wd_active_o = wd_mode_q;

endmodule

// File: rtl/pfc_gate_seq_chk.sv
module pfc_gate_seq_chk #(
   parameter int ONW       = 12,
   parameter int EXT_SHIFT = 2
) (
   input logic clk,
   input logic rst_n,
   input logic bus_ov_i,
   input logic bus_uv_i,
   input logic fault_i,
   input logic gate_o,
   input logic uvlo_req_o,
   input logic wd_active_o
);

   localparam int MAXW = ((1 << ONW) - 1) + (((1 << ONW) - 1) >> EXT_SHIFT);
   localparam int RW   = ONW + 2;

   logic [RW-1:0] hi_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hi_run_q <= '0;
      else if (!gate_o)                        hi_run_q <= '0;
      else if (hi_run_q != {RW{1'b1}})         hi_run_q <= hi_run_q + RW'(1);
   end

   a_r7_ov_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_ov_i, 1) && $past(bus_ov_i, 2) && $past(bus_ov_i, 3)) |-> !gate_o);

   a_r9_fault_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fault_i, 1) && $past(fault_i, 2) && $past(fault_i, 3)) |-> !gate_o);

   a_r8_uv_request: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_uv_i, 1) && $past(bus_uv_i, 2)) |-> uvlo_req_o);

   a_r8_uv_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_uv_i, 1) && !$past(bus_uv_i, 2)) |-> !uvlo_req_o);

   a_r10_wd_clear_on_turnon: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_active_o) |-> $rose(gate_o));

   a_r3_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o |-> (hi_run_q < RW'(MAXW)));

endmodule

bind pfc_gate_seq pfc_gate_seq_chk #(.ONW(ONW), .EXT_SHIFT(EXT_SHIFT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_ov_i    (bus_ov_i),
   .bus_uv_i    (bus_uv_i),
   .fault_i     (fault_i),
   .gate_o      (gate_o),
   .uvlo_req_o  (uvlo_req_o),
   .wd_active_o (wd_active_o)
);

// File: tb/pfc_gate_seq_tb.sv
module pfc_gate_seq_tb;

   localparam int ONW   = 6;
   localparam int WD    = 100;
   localparam int BLANK = 4;
   localparam int XS    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zcd = 0, ocp = 0, ov = 0, uv = 0, flt = 0, near = 0;
   logic [ONW-1:0] ton = 6'd10;
   logic gate, uvlo, wda;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pfc_gate_seq #(
      .ONW(ONW), .WD_CYCLES(WD), .SYNC_STAGES(2),
      .BLANK_CYCLES(BLANK), .EXT_SHIFT(XS), .EXT_EN(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .zcd_i(zcd), .ocp_i(ocp),
      .bus_ov_i(ov), .bus_uv_i(uv), .fault_i(flt),
      .ton_i(ton), .near_zc_i(near),
      .gate_o(gate), .uvlo_req_o(uvlo), .wd_active_o(wda)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_rise(output int lat);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!gate && lat < 4 * WD);
   endtask

   task automatic meas_width(output int w);
      w = 0;
      while (gate) begin
         w++;
         @(negedge clk);
      end
   endtask

   task automatic wait_low();
      while (gate) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
   end

   initial begin
      int lat, w, exp, prev, t0, highs;
      repeat (4) @(negedge clk);
      chk(gate == 0, "R1 gate in reset", gate, 0);
      chk(uvlo == 0, "R1 uvlo in reset", uvlo, 0);
      chk(wda == 1, "R1 wd_active in reset", wda, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(gate == 0, "R1 gate after reset", gate, 0);

      // R2 R3 R4: sweep every on-time code with and without extension
      prev = -1;
      for (int nz = 0; nz < 2; nz++) begin
         for (int t = 0; t < (1 << ONW); t++) begin
            wait_low();
            ton = ONW'(t);
            near = nz[0];
            wait_rise(lat);
            if (prev >= 0) chk(cyc - prev == WD, "R2 forced period", cyc - prev, WD);
            prev = cyc;
            chk(wda == 1, "R10 forced mode flag", wda, 1);
            exp = t + (nz != 0 ? (t >> XS) : 0);
            if (exp == 0) exp = 1;
            meas_width(w);
            chk(w == exp, nz != 0 ? "R4 extended width" : "R3 base width", w, exp);
         end
      end

      // R5 R10: valid rise-then-fall pairs
      ton = 6'd8;
      near = 1'b0;
      for (int k = 0; k < 4; k++) begin
         repeat (3) @(negedge clk);
         zcd = 1'b1;
         repeat (2 + k) @(negedge clk);
         zcd = 1'b0;
         wait_rise(lat);
         prev = cyc;
         chk(lat == 3, "R5 zcd fall to gate", lat, 3);
         chk(wda == 0, "R10 normal clears flag", wda, 1'b0);
         meas_width(w);
         chk(w == 8, "R3 normal width", w, 8);
      end

      // R5: fall without a preceding rise is ignored
      wait_rise(lat);
      chk(cyc - prev == WD, "R2 period after normal", cyc - prev, WD);
      chk(wda == 1, "R10 forced sets flag", wda, 1);
      t0 = cyc;
      zcd = 1'b1;
      wait_low();
      repeat (3) @(negedge clk);
      zcd = 1'b0;
      highs = 0;
      repeat (10) begin
         @(negedge clk);
         if (gate) highs++;
      end
      chk(highs == 0, "R5 lone fall ignored", highs, 0);
      wait_rise(lat);
      chk(cyc - t0 == WD, "R5 next turn-on is forced", cyc - t0, WD);
      meas_width(w);

      // R6: over-current with blanking
      ton = 6'd40;
      ocp = 1'b1;
      wait_rise(lat);
      t0 = cyc;
      meas_width(w);
      chk(w == BLANK + 1, "R6 blanked ocp width", w, BLANK + 1);
      ocp = 1'b0;
      wait_rise(lat);
      chk(cyc - t0 == WD, "R6 restart after ocp", cyc - t0, WD);
      meas_width(w);
      chk(w == 40, "R3 width after ocp", w, 40);

      // R7: over-voltage hold and release pulse
      ov = 1'b1;
      highs = 0;
      repeat (2 * WD) begin
         @(negedge clk);
         if (gate) highs++;
      end
      chk(highs == 0, "R7 gate held low", highs, 0);
      ov = 1'b0;
      wait_rise(lat);
      chk(lat == 3, "R7 release pulse latency", lat, 3);
      meas_width(w);
      chk(w == 40, "R7 release pulse width", w, 40);

      // R8: under-voltage request and release
      uv = 1'b1;
      repeat (2) @(negedge clk);
      chk(uvlo == 1, "R8 uvlo request", uvlo, 1);
      highs = 0;
      repeat (2 * WD) begin
         @(negedge clk);
         if (gate) highs++;
      end
      chk(highs == 0, "R8 gate held low", highs, 0);
      uv = 1'b0;
      repeat (2) @(negedge clk);
      chk(uvlo == 0, "R8 uvlo cleared", uvlo, 0);
      lat = 2;
      while (!gate && lat < 4 * WD) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == WD + 3, "R8 restart latency", lat, WD + 3);
      chk(wda == 1, "R10 flag after uv", wda, 1);
      meas_width(w);

      // R9: fault flag
      flt = 1'b1;
      highs = 0;
      repeat (2 * WD) begin
         @(negedge clk);
         if (gate) highs++;
      end
      chk(highs == 0, "R9 gate held low", highs, 0);
      chk(uvlo == 0, "R9 no uvlo request", uvlo, 0);
      flt = 1'b0;
      wait_rise(lat);
      chk(lat == WD + 3, "R9 restart latency", lat, WD + 3);
      meas_width(w);
      chk(w == 40, "R9 width after fault", w, 40);

      summary();
      $finish;
   end

endmodule